// File: doc/BRIEF.md
# Multiplexed Score Display Refresh Sequencer

This block refreshes five six-digit BCD displays that share one 4-bit data bus and one set of six digit-select lines. It holds a small digit store (five displays by six positions) that is filled through a single write port. On every refresh tick it blanks the displays and walks the five displays in a fixed order. For each display it drives the one-hot enable of the current digit position, puts that display's digit on the bus and pulses that display's latch line. It then unblanks and moves to the next position, wrapping after the sixth.

Four of the latch lines sit on a 4-bit port that another function (lamp addressing) also drives. Outside a refresh burst that port follows the lamp input. During the burst the port is parked at all ones, which is an address the lamp decoder never uses. When the burst ends the port gets back the value it held just before the burst. The fifth latch line is a separate output. A latch only captures while blank is high, and the block also outputs that gated capture event for each display.

Top module: `score_refresh_seq`

## Requirements
- R1: Reset, which is synchronous and active high, sets these values: blank_o = 1, shared_port_o = 4'hF, aux_latch_n_o = 1, digit_en_o = 0, latch_fire_o = 0. Within six cycles after reset is released, every stored digit is cleared to 0. Writes in that window are dropped.
- R2: A tick sampled while no burst is running makes blank_o high in the next cycle. blank_o then stays high for exactly 16 cycles: 1 park cycle plus 3 cycles per display. It never stays high longer than BLANK_MAX cycles (default 18750, which is 150 us at 125 MHz).
- R3: In each burst the latch events fire exactly once per display, in the order display 0, 1, 2, 3, 4. Each event lasts one cycle. Displays 0 to 3 strobe by driving bit d of shared_port_o low. Display 4 strobes by driving aux_latch_n_o low.
- R4: When display d fires, bcd_o equals the digit stored for display d at the current position p, and digit_en_o has only bit p set. bcd_o is stable in the cycle before the event and in the cycle after it.
- R5: latch_fire_o[d] is high only when blank_o is high and the strobe line for display d is low. While blank_o is low, a low value on the shared port (lamp data) produces no latch event.
- R6: While blank_o is high, shared_port_o and aux_latch_n_o are all ones, except the single line being strobed.
- R7: In the first cycle after blank_o falls, shared_port_o equals the value it had in the cycle before blank_o rose. After that, while no burst runs, it follows lamp_port_i with one cycle of delay. Before the first burst it stays at 4'hF.
- R8: The digit position starts at 0 and advances by one after each burst, going 0,1,2,3,4,5,0. It is visible as the set bit of digit_en_o.
- R9: A write on the write port stores wr_val_i at display wr_disp_i and position wr_pos_i. Writes with wr_disp_i > 4 or wr_pos_i > 5 are ignored. A write in the cycle a burst starts, or during the burst, does not change the digits of that burst. It shows in later bursts.
- R10: A tick that arrives while a burst runs is held. blank_o then falls for exactly one cycle, and a new burst starts at the next position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Refresh request pulse |
| wr_en_i | input | 1 | Digit store write enable |
| wr_disp_i | input | 3 | Display index of the write (0-4) |
| wr_pos_i | input | 3 | Digit position of the write (0-5) |
| wr_val_i | input | 4 | BCD value to store |
| lamp_port_i | input | 4 | Value the lamp function wants on the shared port |
| blank_o | output | 1 | Blank line, high blanks all displays |
| digit_en_o | output | 6 | One-hot digit position enable |
| bcd_o | output | 4 | BCD data bus |
| shared_port_o | output | 4 | Shared port: lamp value, or latch strobes 0-3 (active low) during a burst |
| aux_latch_n_o | output | 1 | Active-low latch strobe of display 4 |
| latch_fire_o | output | 5 | Gated latch event per display (strobe low while blanked) |

## Verification
The bench runs bursts after random writes and random lamp values. Each latch event is checked against a model store, and so are the firing order and the setup and hold of the bus. A design that reads the store late, or shifts the order, would put a digit from the wrong display or position on the bus. The bench writes to the last display in the middle of a burst and expects the old value. A design without a snapshot would leak the new digit. It returns to that position six bursts later and expects the new value there. Other directed cases are a low lamp value while unblanked (a design that does not gate the strobe would fire a latch), a tick during a burst (a design that drops it would leave blank low), restore of the pre-burst port value, and wrap of the position after six bursts.

// File: rtl/score_refresh_pkg.sv
package score_refresh_pkg;
  typedef enum logic [2:0] {
    ST_CLR,
    ST_IDLE,
    ST_PARK,
    ST_SET,
    ST_STB,
    ST_HLD
  } seq_state_t;
endpackage

// File: rtl/score_digit_bank.sv
// One display's digit column: simple dual port, read-first, no reset (RAM-style).
module score_digit_bank #(
  parameter int DEPTH = 6,
  parameter int DW    = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/score_strobe_gate.sv
// A latch only captures when its strobe line is low and the displays are blanked.
module score_strobe_gate #(
  parameter int NUM_DISP = 5
) (
  input  logic                  blank,
  input  logic [NUM_DISP-2:0]   port_lines,
  input  logic                  aux_line_n,
  output logic [NUM_DISP-1:0]   fire
);
  assign fire = {~aux_line_n, ~port_lines} & {NUM_DISP{blank}};
endmodule

// File: rtl/score_refresh_ctrl.sv
module score_refresh_ctrl
  import score_refresh_pkg::*;
#(
  parameter int NUM_DISP = 5,
  parameter int NUM_POS  = 6,
  parameter int DW       = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick_i,
  input  logic [NUM_DISP-2:0]          lamp_port_i,
  input  logic [NUM_DISP*DW-1:0]       snap_i,
  output logic                         blank_o,
  output logic [NUM_DISP-2:0]          port_o,
  output logic                         aux_n_o,
  output logic [NUM_POS-1:0]           digit_en_o,
  output logic [DW-1:0]                bcd_o,
  output logic                         rd_en_o,
  output logic                         clr_en_o,
  output logic [$clog2(NUM_POS)-1:0]   pos_o
);
  localparam int PW  = NUM_DISP - 1;
  localparam int PIW = $clog2(NUM_POS);
  localparam int DIW = $clog2(NUM_DISP);

  seq_state_t     st_q;
  logic [DIW-1:0] disp_q;
  logic [PIW-1:0] pos_q;
  logic           pend_q;
  logic [PW-1:0]  save_q;
  logic           go;

  assign go       = (st_q == ST_IDLE) && (tick_i || pend_q);
  assign rd_en_o  = go;
  assign clr_en_o = (st_q == ST_CLR);
  assign pos_o    = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_CLR;
      disp_q     <= '0;
      pos_q      <= '0;
      pend_q     <= 1'b0;
      save_q     <= '1;
      blank_o    <= 1'b1;
      port_o     <= '1;
      aux_n_o    <= 1'b1;
      digit_en_o <= '0;
      bcd_o      <= '0;
    end else begin
      if (go)          pend_q <= 1'b0;
      else if (tick_i) pend_q <= 1'b1;

      case (st_q)
        ST_CLR: begin
          if (pos_q == PIW'(NUM_POS - 1)) begin
            pos_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (go) begin
            st_q    <= ST_PARK;
            blank_o <= 1'b1;
            save_q  <= port_o;
            port_o  <= '1;
          end else if (!blank_o) begin
            port_o <= lamp_port_i;
          end
        end
        ST_PARK: begin
          st_q       <= ST_SET;
          disp_q     <= '0;
          bcd_o      <= snap_i[0 +: DW];
          digit_en_o <= NUM_POS'(1) << pos_q;
        end
        ST_SET: begin
          st_q <= ST_STB;
          if (32'(disp_q) < PW) port_o  <= ~(PW'(1) << disp_q);
          else                  aux_n_o <= 1'b0;
        end
        ST_STB: begin
          st_q    <= ST_HLD;
          port_o  <= '1;
          aux_n_o <= 1'b1;
        end
        ST_HLD: begin
          if (disp_q == DIW'(NUM_DISP - 1)) begin
            st_q    <= ST_IDLE;
            blank_o <= 1'b0;
            port_o  <= save_q;
            pos_q   <= (pos_q == PIW'(NUM_POS - 1)) ? '0 : pos_q + 1'b1;
          end else begin
            st_q   <= ST_SET;
            disp_q <= disp_q + 1'b1;
            bcd_o  <= snap_i[(32'(disp_q) + 1) * DW +: DW];
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/score_refresh_seq.sv
module score_refresh_seq #(
  parameter int NUM_DISP  = 5,
  parameter int NUM_POS   = 6,
  parameter int DW        = 4,
  parameter int BLANK_MAX = 18750
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(NUM_DISP)-1:0]   wr_disp_i,
  input  logic [$clog2(NUM_POS)-1:0]    wr_pos_i,
  input  logic [DW-1:0]                 wr_val_i,
  input  logic [NUM_DISP-2:0]           lamp_port_i,
  output logic                          blank_o,
  output logic [NUM_POS-1:0]            digit_en_o,
  output logic [DW-1:0]                 bcd_o,
  output logic [NUM_DISP-2:0]           shared_port_o,
  output logic                          aux_latch_n_o,
  output logic [NUM_DISP-1:0]           latch_fire_o
);
  localparam int PIW = $clog2(NUM_POS);
  localparam int DIW = $clog2(NUM_DISP);

  logic [NUM_DISP*DW-1:0] snap;
  logic                   rd_en;
  logic                   clr_en;
  logic [PIW-1:0]         pos;
  logic                   wr_ok;

  assign wr_ok = wr_en_i && !clr_en && (32'(wr_pos_i) < NUM_POS);

  for (genvar d = 0; d < NUM_DISP; d++) begin : g_bank
    logic           we_d;
    logic [PIW-1:0] waddr_d;
    logic [DW-1:0]  wdata_d;

    assign we_d    = clr_en || (wr_ok && (wr_disp_i == DIW'(d)));
    assign waddr_d = clr_en ? pos : wr_pos_i;
    assign wdata_d = clr_en ? '0 : wr_val_i;

    score_digit_bank #(.DEPTH(NUM_POS), .DW(DW)) u_bank (
      .clk   (clk),
      .we    (we_d),
      .waddr (waddr_d),
      .wdata (wdata_d),
      .re    (rd_en),
      .raddr (pos),
      .rdata (snap[d*DW +: DW])
    );
  end

  score_refresh_ctrl #(.NUM_DISP(NUM_DISP), .NUM_POS(NUM_POS), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .lamp_port_i(lamp_port_i),
    .snap_i     (snap),
    .blank_o    (blank_o),
    .port_o     (shared_port_o),
    .aux_n_o    (aux_latch_n_o),
    .digit_en_o (digit_en_o),
    .bcd_o      (bcd_o),
    .rd_en_o    (rd_en),
    .clr_en_o   (clr_en),
    .pos_o      (pos)
  );

  score_strobe_gate #(.NUM_DISP(NUM_DISP)) u_gate (
    .blank      (blank_o),
    .port_lines (shared_port_o),
    .aux_line_n (aux_latch_n_o),
    .fire       (latch_fire_o)
  );
endmodule

// File: rtl/score_refresh_chk.sv
module score_refresh_chk #(
  parameter int NUM_DISP  = 5,
  parameter int NUM_POS   = 6,
  parameter int DW        = 4,
  parameter int BLANK_MAX = 18750
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick_i,
  input logic                 blank_o,
  input logic [NUM_POS-1:0]   digit_en_o,
  input logic [DW-1:0]        bcd_o,
  input logic [NUM_DISP-2:0]  shared_port_o,
  input logic                 aux_latch_n_o,
  input logic [NUM_DISP-1:0]  latch_fire_o
);
  logic [31:0] run_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      run_q <= blank_o ? run_q + 1 : '0;
      if (!blank_o) seen_q <= 1'b1;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(latch_fire_o)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|latch_fire_o) |=> !(|latch_fire_o)); // R3
  AST_BUS_SETUP: assert property (@(posedge clk) disable iff (rst)
    (|latch_fire_o) |-> ($stable(bcd_o) && $stable(digit_en_o))); // R4
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|latch_fire_o) |=> $stable(bcd_o)); // R4
  AST_PORT_PARKED: assert property (@(posedge clk) disable iff (rst)
    blank_o |-> ($countones({aux_latch_n_o, shared_port_o}) >= NUM_DISP - 1)); // R6
  AST_DIGIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digit_en_o)); // R8
  AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (rst)
    (seen_q && blank_o) |-> (run_q < BLANK_MAX)); // R2
  AST_TICK_STARTS: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !blank_o) |=> blank_o); // R2
endmodule

bind score_refresh_seq score_refresh_chk #(
  .NUM_DISP (NUM_DISP),
  .NUM_POS  (NUM_POS),
  .DW       (DW),
  .BLANK_MAX(BLANK_MAX)
) u_chk (.*);

// File: tb/tb_score_refresh_seq.sv
module tb_score_refresh_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_disp_i = '0;
  logic [2:0] wr_pos_i = '0;
  logic [3:0] wr_val_i = '0;
  logic [3:0] lamp_port_i = '0;
  logic       blank_o;
  logic [5:0] digit_en_o;
  logic [3:0] bcd_o;
  logic [3:0] shared_port_o;
  logic       aux_latch_n_o;
  logic [4:0] latch_fire_o;

  score_refresh_seq dut (.*);

  always #4 clk = ~clk;

  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;
  logic [3:0] model [5][6];
  int         exp_pos = 0;
  logic [3:0] cur_lamp = 4'h0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] pos_mask(input int p);
    return 6'(1) << p;
  endfunction

  task automatic write_digit(input int d, input int p, input logic [3:0] v);
    wr_en_i = 1'b1; wr_disp_i = 3'(d); wr_pos_i = 3'(p); wr_val_i = v;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (d < 5 && p < 6) model[d][p] = v;
  endtask

  task automatic set_lamp(input logic [3:0] v);
    lamp_port_i = v; cur_lamp = v;
    @(negedge clk); @(negedge clk);
  endtask

  // Caller is at a negedge. issue=0 means the burst was already requested.
  task automatic run_burst(input bit issue, input logic [3:0] saved,
                           input logic [3:0] lamp_mid, input bit mid_wr, input bit mid_tick);
    int nb = 0;
    int next_d = 0;
    logic [3:0] pbcd = bcd_o;
    bit post = 0;
    logic [3:0] post_bcd = '0;
    logic [3:0] new_val = ~model[4][exp_pos];
    if (issue) tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    lamp_port_i = lamp_mid;
    chk(blank_o == 1'b1, "R2 blank after tick", int'(blank_o), 1);
    if (!issue) chk(blank_o == 1'b1, "R10 held tick serviced", int'(blank_o), 1);
    for (int c = 0; c < 40; c++) begin
      if (!blank_o) break;
      nb++;
      if (post) begin
        chk(bcd_o == post_bcd, "R4 hold after strobe", int'(bcd_o), int'(post_bcd));
        post = 0;
      end
      chk({aux_latch_n_o, shared_port_o} == ~latch_fire_o, "R6 parked port",
          int'({aux_latch_n_o, shared_port_o}), int'(~latch_fire_o));
      if (latch_fire_o != 0) begin
        chk(latch_fire_o == (5'(1) << next_d), "R3 strobe order", int'(latch_fire_o), 1 << next_d);
        chk(bcd_o == model[next_d][exp_pos], "R4 digit value", int'(bcd_o), int'(model[next_d][exp_pos]));
        chk(bcd_o == pbcd, "R4 setup before strobe", int'(bcd_o), int'(pbcd));
        chk(digit_en_o == pos_mask(exp_pos), "R8 digit position", int'(digit_en_o), int'(pos_mask(exp_pos)));
        post = 1; post_bcd = bcd_o; next_d++;
      end
      pbcd = bcd_o;
      if (mid_wr && nb == 2) begin
        wr_en_i = 1'b1; wr_disp_i = 3'd4; wr_pos_i = 3'(exp_pos); wr_val_i = new_val;
      end
      if (mid_wr && nb == 3) wr_en_i = 1'b0;
      if (mid_tick && nb == 4) tick_i = 1'b1;
      if (mid_tick && nb == 5) tick_i = 1'b0;
      @(negedge clk);
    end
    chk(nb == 16, "R2 blank length", nb, 16);
    chk(next_d == 5, "R3 strobe count", next_d, 5);
    chk(shared_port_o == saved, "R7 restore after burst", int'(shared_port_o), int'(saved));
    chk(latch_fire_o == 0, "R5 no fire unblanked", int'(latch_fire_o), 0);
    if (mid_wr) model[4][exp_pos] = new_val;
    exp_pos = (exp_pos + 1) % 6;
    cur_lamp = lamp_mid;
    if (!mid_tick) begin
      @(negedge clk);
      chk(shared_port_o == lamp_mid, "R7 follow lamp", int'(shared_port_o), int'(lamp_mid));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] lv;
    logic [3:0] sv;
    void'($urandom(32'd4711));
    for (int d = 0; d < 5; d++) for (int p = 0; p < 6; p++) model[d][p] = 4'h0;
    repeat (4) @(negedge clk);
    chk(blank_o == 1'b1, "R1 reset blank", int'(blank_o), 1);
    chk(shared_port_o == 4'hF, "R1 reset port", int'(shared_port_o), 15);
    chk(aux_latch_n_o == 1'b1, "R1 reset aux", int'(aux_latch_n_o), 1);
    chk(digit_en_o == 6'h0, "R1 reset digit enable", int'(digit_en_o), 0);
    chk(latch_fire_o == 5'h0, "R1 reset fire", int'(latch_fire_o), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(shared_port_o == 4'hF, "R7 parked before first burst", int'(shared_port_o), 15);
    chk(latch_fire_o == 5'h0, "R5 no fire before first burst", int'(latch_fire_o), 0);

    // R1: store cleared, first burst shows zeros
    lv = 4'($urandom);
    run_burst(1, 4'hF, lv, 0, 0);

    // R9: random writes, including out-of-range indices that must be ignored
    for (int i = 0; i < 40; i++)
      write_digit($urandom % 6, $urandom % 7, 4'($urandom));

    // R5: low lamp value while unblanked
    set_lamp(4'h0);
    chk(shared_port_o == 4'h0, "R7 lamp visible idle", int'(shared_port_o), 0);
    chk(latch_fire_o == 5'h0, "R5 lamp low no latch", int'(latch_fire_o), 0);

    // R8: several bursts across the wrap
    for (int b = 0; b < 7; b++) begin
      sv = cur_lamp;
      lv = 4'($urandom);
      run_burst(1, sv, lv, 0, 0);
      write_digit($urandom % 5, $urandom % 6, 4'($urandom));
      @(negedge clk);
    end

    // R9: write during burst lands later
    sv = cur_lamp;
    run_burst(1, sv, 4'hA, 1, 0);
    @(negedge clk);
    for (int b = 0; b < 6; b++) begin
      sv = cur_lamp;
      run_burst(1, sv, 4'($urandom), 0, 0);
      @(negedge clk);
    end

    // R10: tick during burst is held
    set_lamp(4'h5);
    run_burst(1, 4'h5, 4'h3, 0, 1);
    run_burst(0, 4'h5, 4'h3, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule